// File: doc/BRIEF.md
# VLAN Membership Table with Indirect Command Access

This block stores, for every 12-bit VLAN identifier, the set of switch ports that belong to that VLAN, together with two per-VLAN flags: a source-check flag and a mirror flag. Software does not address the table directly. It first loads the VLAN identifier into an index register. It then writes an access register that carries a command code and, for a write, the entry data. The block carries out the command and clears the command field back to idle when the work is done. Software polls that field before and after each command. Read results come back in the same access register, in the fields that a write would have supplied.

A second, independent port serves the forwarding path. It takes a VLAN identifier and an ingress port number. One cycle later it returns the entry's port mask and source-check flag, plus a drop verdict. A frame is dropped when source checking is enabled for its VLAN and its ingress port is not a member.

The command sequencer is a four-state machine. ST_IDLE accepts host writes. An accepted read command moves it to ST_READ_FETCH, which launches the table read, then to ST_READ_LOAD, which copies the entry into the access register and returns to ST_IDLE. An accepted write command moves it to ST_WRITE_COMMIT, which stores the entry and returns to ST_IDLE. A command code of idle or the reserved code leaves the machine in ST_IDLE. Table contents are undefined after reset until written.

Top module: `vlan_member_tbl`

## Requirements
- R1: After reset, both the index register (host_sel=0) and the access register (host_sel=1) read back as zero.
- R2: The index register holds a 12-bit VLAN identifier in bits [11:0]. Bits above 11 of a write are discarded and read back as zero.
- R3: The access register layout is as follows. Bits [1:0] hold the command: 0 idle, 1 read, 2 write. Bits [9:2] hold the port mask, with bit 2 for port 0. Bit 28 is source-check and bit 29 is mirror. All other bits read as zero whatever was written.
- R4: A write command stores the mask, source-check and mirror values written with it into the entry selected by the index. The command field reads 2 in the cycle after acceptance and 0 in the cycle after that.
- R5: A read command loads the selected entry's mask, source-check and mirror into the access register. The command field reads 1 for the two cycles after acceptance and then 0, with the entry data present.
- R6: A command code of 0 or 3 performs no table operation. It still captures the written mask and flags into the access register, and the command field reads 0 in the next cycle.
- R7: While a command is in progress, host writes to the access register and to the index register are ignored.
- R8: The lookup port returns the port mask and source-check flag of the entry addressed by lk_vid, registered one clock after lk_vid is presented.
- R9: lk_drop is 1 exactly when the looked-up source-check flag is 1 and the mask bit of the ingress port given with that lookup is 0. It is aligned with the lookup result.
- R10: Each of the 4096 entries is independent. VLAN 0 and VLAN 4095 are both addressable, and writing one leaves the others unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_we | input | 1 | Host write strobe, one cycle per write |
| host_sel | input | 1 | Register select: 0 index, 1 access |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Contents of the selected register (combinational) |
| lk_vid | input | 12 | VLAN identifier to look up |
| lk_port | input | 3 | Ingress port number for the membership check |
| lk_mask | output | 8 | Port mask of the looked-up entry |
| lk_src_chk | output | 1 | Source-check flag of the looked-up entry |
| lk_drop | output | 1 | Membership-check drop verdict |

## Verification
The hardest case to reach from the ports is a host write that lands inside the short window in which a read command is still running. That window lasts only two cycles, and a polling host never writes during it. The stimulus issues a read command and then, on the next two clocks with no polling in between, writes a new write command with a different mask and then a new index. The access register must then return the original entry, the index must be unchanged, and a lookup must show the entry was not rewritten.

// File: rtl/vmt_pkg.sv
package vmt_pkg;

    // Access-register field positions that software depends on
    localparam int ACC_CMD_W    = 2;
    localparam int ACC_MASK_LSB = 2;
    localparam int ACC_SRC_BIT  = 28;
    localparam int ACC_MIR_BIT  = 29;
    localparam int HOST_DW      = 32;

    typedef enum logic [1:0] {
        CMD_IDLE  = 2'd0,
        CMD_READ  = 2'd1,
        CMD_WRITE = 2'd2,
        CMD_RSVD  = 2'd3
    } tbl_cmd_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_READ_FETCH,
        ST_READ_LOAD,
        ST_WRITE_COMMIT
    } tbl_state_e;

endpackage

// File: rtl/vmt_store.sv
module vmt_store
    import vmt_pkg::*;
#(
    parameter int VID_W = 12,
    parameter int EW    = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic             re,
    input  logic [VID_W-1:0] addr,
    input  logic [EW-1:0]    wdata,
    output logic [EW-1:0]    host_q,
    input  logic [VID_W-1:0] lk_vid,
    output logic [EW-1:0]    lk_q
);
    localparam int DEPTH = 1 << VID_W;

    // Entry layout: {mirror, source-check, mask}
    logic [EW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[addr] <= wdata;
        end
    end

    // Both read ports are registered; a lookup in the commit cycle sees old data
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            host_q <= '0;
            lk_q   <= '0;
        end else begin
            if (re) begin
                host_q <= mem[addr];
            end
            lk_q <= mem[lk_vid];
        end
    end

endmodule

// File: rtl/vmt_cmd_fsm.sv
module vmt_cmd_fsm
    import vmt_pkg::*;
#(
    parameter int VID_W = 12,
    parameter int PORTS = 8,
    parameter int EW    = PORTS + 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               host_we,
    input  logic               host_sel,
    input  logic [HOST_DW-1:0] host_wdata,
    output logic [HOST_DW-1:0] host_rdata,
    output logic               mem_we,
    output logic               mem_re,
    output logic [VID_W-1:0]   mem_addr,
    output logic [EW-1:0]      mem_wdata,
    input  logic [EW-1:0]      mem_rdata,
    output logic [VID_W-1:0]   idx_o,
    output logic [1:0]         cmd_o,
    output logic               busy_o,
    output logic [PORTS-1:0]   mask_o
);
    tbl_state_e       state_q, state_d;
    tbl_cmd_e         cmd_q;
    tbl_cmd_e         cmd_in;
    logic [VID_W-1:0] idx_q;
    logic [PORTS-1:0] mask_q;
    logic             src_q;
    logic             mir_q;
    logic             acc_wr;
    logic             idx_wr;
    logic             unused_wbits;

    assign unused_wbits = ^host_wdata;
    assign cmd_in = tbl_cmd_e'(host_wdata[ACC_CMD_W-1:0]);
    assign acc_wr = host_we &  host_sel & (state_q == ST_IDLE);
    assign idx_wr = host_we & ~host_sel & (state_q == ST_IDLE);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (acc_wr && cmd_in == CMD_READ) begin
                    state_d = ST_READ_FETCH;
                end else if (acc_wr && cmd_in == CMD_WRITE) begin
                    state_d = ST_WRITE_COMMIT;
                end
            end
            ST_READ_FETCH:   state_d = ST_READ_LOAD;
            ST_READ_LOAD:    state_d = ST_IDLE;
            ST_WRITE_COMMIT: state_d = ST_IDLE;
            default:         state_d = ST_IDLE;
        endcase
    end

    // Register outputs: index, command and entry data
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q  <= '0;
            cmd_q  <= CMD_IDLE;
            mask_q <= '0;
            src_q  <= 1'b0;
            mir_q  <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (idx_wr) begin
                        idx_q <= host_wdata[VID_W-1:0];
                    end
                    if (acc_wr) begin
                        mask_q <= host_wdata[ACC_MASK_LSB +: PORTS];
                        src_q  <= host_wdata[ACC_SRC_BIT];
                        mir_q  <= host_wdata[ACC_MIR_BIT];
                        if (cmd_in == CMD_READ || cmd_in == CMD_WRITE) begin
                            cmd_q <= cmd_in;
                        end else begin
                            cmd_q <= CMD_IDLE;
                        end
                    end
                end
                ST_READ_FETCH: begin
                    cmd_q <= cmd_q;
                end
                ST_READ_LOAD: begin
                    mask_q <= mem_rdata[PORTS-1:0];
                    src_q  <= mem_rdata[PORTS];
                    mir_q  <= mem_rdata[PORTS+1];
                    cmd_q  <= CMD_IDLE;
                end
                ST_WRITE_COMMIT: begin
                    cmd_q <= CMD_IDLE;
                end
                default: begin
                    cmd_q <= CMD_IDLE;
                end
            endcase
        end
    end

    assign mem_we    = (state_q == ST_WRITE_COMMIT);
    assign mem_re    = (state_q == ST_READ_FETCH);
    assign mem_addr  = idx_q;
    assign mem_wdata = {mir_q, src_q, mask_q};

    always_comb begin
        host_rdata = '0;
        if (host_sel) begin
            host_rdata[ACC_CMD_W-1:0]            = cmd_q;
            host_rdata[ACC_MASK_LSB +: PORTS]    = mask_q;
            host_rdata[ACC_SRC_BIT]              = src_q;
            host_rdata[ACC_MIR_BIT]              = mir_q;
        end else begin
            host_rdata[VID_W-1:0] = idx_q;
        end
    end

    assign idx_o  = idx_q;
    assign cmd_o  = cmd_q;
    assign busy_o = (state_q != ST_IDLE);
    assign mask_o = mask_q;

endmodule

// File: rtl/vmt_member_chk.sv
module vmt_member_chk #(
    parameter int PORTS  = 8,
    parameter int PORT_W = $clog2(PORTS),
    parameter int EW     = PORTS + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PORT_W-1:0] lk_port,
    input  logic [EW-1:0]     entry_q,
    output logic [PORTS-1:0]  lk_mask,
    output logic              lk_src_chk,
    output logic              lk_drop
);
    logic [PORT_W-1:0] port_q;
    logic              unused_mir;

    // Port number travels beside the registered table read
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            port_q <= '0;
        end else begin
            port_q <= lk_port;
        end
    end

    assign unused_mir = entry_q[PORTS+1];
    assign lk_mask    = entry_q[PORTS-1:0];
    assign lk_src_chk = entry_q[PORTS];
    assign lk_drop    = entry_q[PORTS] & ~entry_q[port_q];

endmodule

// File: rtl/vlan_member_tbl.sv
module vlan_member_tbl
    import vmt_pkg::*;
#(
    parameter int VID_W  = 12,
    parameter int PORTS  = 8,
    parameter int PORT_W = $clog2(PORTS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               host_we,
    input  logic               host_sel,
    input  logic [HOST_DW-1:0] host_wdata,
    output logic [HOST_DW-1:0] host_rdata,
    input  logic [VID_W-1:0]   lk_vid,
    input  logic [PORT_W-1:0]  lk_port,
    output logic [PORTS-1:0]   lk_mask,
    output logic               lk_src_chk,
    output logic               lk_drop
);
    localparam int EW = PORTS + 2;

    logic             mem_we;
    logic             mem_re;
    logic [VID_W-1:0] mem_addr;
    logic [EW-1:0]    mem_wdata;
    logic [EW-1:0]    host_q;
    logic [EW-1:0]    lk_q;
    logic [VID_W-1:0] idx_q;
    logic [1:0]       acc_cmd;
    logic             busy;
    logic [PORTS-1:0] acc_mask;

    vmt_cmd_fsm #(.VID_W(VID_W), .PORTS(PORTS), .EW(EW)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_we    (host_we),
        .host_sel   (host_sel),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .mem_we     (mem_we),
        .mem_re     (mem_re),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .mem_rdata  (host_q),
        .idx_o      (idx_q),
        .cmd_o      (acc_cmd),
        .busy_o     (busy),
        .mask_o     (acc_mask)
    );

    vmt_store #(.VID_W(VID_W), .EW(EW)) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (mem_we),
        .re     (mem_re),
        .addr   (mem_addr),
        .wdata  (mem_wdata),
        .host_q (host_q),
        .lk_vid (lk_vid),
        .lk_q   (lk_q)
    );

    vmt_member_chk #(.PORTS(PORTS), .PORT_W(PORT_W), .EW(EW)) u_member (
        .clk        (clk),
        .rst_n      (rst_n),
        .lk_port    (lk_port),
        .entry_q    (lk_q),
        .lk_mask    (lk_mask),
        .lk_src_chk (lk_src_chk),
        .lk_drop    (lk_drop)
    );

endmodule

// File: rtl/vmt_checks.sv
module vmt_checks #(
    parameter int VID_W = 12,
    parameter int PORTS = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             host_we,
    input logic             host_sel,
    input logic [31:0]      host_wdata,
    input logic [1:0]       acc_cmd,
    input logic             busy,
    input logic [VID_W-1:0] idx_q,
    input logic [PORTS-1:0] acc_mask,
    input logic             lk_drop,
    input logic             lk_src_chk
);
    AST_CMD_NEVER_RSVD: assert property (@(posedge clk) disable iff (!rst_n) acc_cmd != 2'd3); // R6
    AST_RSVD_STAYS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && host_we && host_sel && host_wdata[1:0] == 2'd3) |=> (acc_cmd == 2'd0 && !busy)); // R6
    AST_WRITE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_cmd == 2'd2) |=> (acc_cmd == 2'd0)); // R4
    AST_READ_TWO_CYCLES: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_cmd == 2'd1 && $past(acc_cmd) == 2'd1) |=> (acc_cmd == 2'd0)); // R5
    AST_BUSY_HOLDS_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(idx_q)); // R7
    AST_WRITE_HOLDS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_cmd == 2'd2) |=> $stable(acc_mask)); // R7
    AST_DROP_NEEDS_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        lk_drop |-> lk_src_chk); // R9
endmodule

bind vlan_member_tbl vmt_checks #(.VID_W(VID_W), .PORTS(PORTS)) u_checks (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_we    (host_we),
    .host_sel   (host_sel),
    .host_wdata (host_wdata),
    .acc_cmd    (acc_cmd),
    .busy       (busy),
    .idx_q      (idx_q),
    .acc_mask   (acc_mask),
    .lk_drop    (lk_drop),
    .lk_src_chk (lk_src_chk)
);

// File: tb/vlan_member_tbl_tb.sv
module vlan_member_tbl_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_we = 1'b0;
    logic        host_sel = 1'b0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic [11:0] lk_vid = '0;
    logic [2:0]  lk_port = '0;
    logic [7:0]  lk_mask;
    logic        lk_src_chk;
    logic        lk_drop;

    int checks = 0;
    int fails  = 0;

    typedef struct {
        logic [7:0] mask;
        logic       src;
        logic       drop;
        string      tag;
    } lk_exp_t;

    lk_exp_t    sb_q[$];
    logic [9:0] model [int];

    always #(CLK_PERIOD/2) clk = ~clk;

    vlan_member_tbl u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_we    (host_we),
        .host_sel   (host_sel),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .lk_vid     (lk_vid),
        .lk_port    (lk_port),
        .lk_mask    (lk_mask),
        .lk_src_chk (lk_src_chk),
        .lk_drop    (lk_drop)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] acc_word(input logic [7:0] m, input logic s,
                                             input logic r, input logic [1:0] c);
        return {2'b00, r, s, 18'd0, m, c};
    endfunction

    // Called at a falling edge; returns at the next falling edge
    task automatic host_write(input logic sel, input logic [31:0] d);
        host_sel = sel; host_wdata = d; host_we = 1'b1;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic host_rd(input logic sel, output logic [31:0] d);
        host_sel = sel;
        #1;
        d = host_rdata;
    endtask

    task automatic poll_idle(input string req);
        logic [31:0] v;
        bit ok = 0;
        for (int i = 0; i < 10 && !ok; i++) begin
            host_rd(1'b1, v);
            if (v[1:0] == 2'd0) ok = 1;
            else @(negedge clk);
        end
        chk({req, " poll idle"}, {31'd0, ok}, 32'd1);
    endtask

    task automatic tbl_write(input logic [11:0] vid, input logic [7:0] m,
                             input logic s, input logic r, input logic [31:0] junk);
        logic [31:0] v;
        poll_idle("R4");
        host_write(1'b0, {20'd0, vid});
        host_write(1'b1, junk | acc_word(m, s, r, 2'd2));
        host_rd(1'b1, v);
        chk("R4 busy after write cmd", {30'd0, v[1:0]}, 32'd2);
        @(negedge clk);
        host_rd(1'b1, v);
        chk("R3/R4 idle and fields after write", v, acc_word(m, s, r, 2'd0));
        model[int'(vid)] = {r, s, m};
    endtask

    task automatic tbl_read(input logic [11:0] vid);
        logic [31:0] v;
        logic [9:0]  e;
        e = model[int'(vid)];
        poll_idle("R5");
        host_write(1'b0, {20'd0, vid});
        host_write(1'b1, acc_word(8'h00, 1'b0, 1'b0, 2'd1));
        host_rd(1'b1, v);
        chk("R5 busy cycle 1", {30'd0, v[1:0]}, 32'd1);
        @(negedge clk);
        host_rd(1'b1, v);
        chk("R5 busy cycle 2", {30'd0, v[1:0]}, 32'd1);
        @(negedge clk);
        host_rd(1'b1, v);
        chk("R5 read result", v, acc_word(e[7:0], e[8], e[9], 2'd0));
    endtask

    // Driver: present one lookup per cycle and push the expected result
    task automatic lk_issue(input logic [11:0] vid, input logic [2:0] port, input string tag);
        lk_exp_t x;
        logic [9:0] e;
        e = model[int'(vid)];
        lk_vid = vid; lk_port = port;
        x.mask = e[7:0]; x.src = e[8]; x.drop = e[8] & ~e[port]; x.tag = tag;
        sb_q.push_back(x);
        @(negedge clk);
    endtask

    // Monitor: one registered result per issued lookup
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb_q.size() > 0) begin
                lk_exp_t x;
                x = sb_q.pop_front();
                chk({x.tag, " lk_mask"}, {24'd0, lk_mask}, {24'd0, x.mask});
                chk({x.tag, " lk_src_chk"}, {31'd0, lk_src_chk}, {31'd0, x.src});
                chk({x.tag, " lk_drop"}, {31'd0, lk_drop}, {31'd0, x.drop});
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired act=running exp=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        // R1: reset state
        host_rd(1'b0, v); chk("R1 index after reset", v, 32'd0);
        host_rd(1'b1, v); chk("R1 access after reset", v, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: index width
        host_write(1'b0, 32'hFFFF_F123);
        host_rd(1'b0, v); chk("R2 index truncation", v, 32'h0000_0123);

        // R3/R4: writes with stray bits in unused positions
        tbl_write(12'h123, 8'hA5, 1'b1, 1'b0, 32'h8010_0400);
        tbl_write(12'h000, 8'h01, 1'b0, 1'b1, 32'h4000_0000);
        tbl_write(12'hFFF, 8'h80, 1'b1, 1'b1, 32'h0FF0_FC00);
        tbl_write(12'h200, 8'h11, 1'b0, 1'b0, 32'h0);

        // R5: read back
        tbl_read(12'h123);
        tbl_read(12'h000);
        tbl_read(12'hFFF);

        // R8/R9: lookups with varied ingress ports
        lk_issue(12'h123, 3'd0, "R8/R9 member no drop");
        lk_issue(12'h123, 3'd1, "R9 non-member drop");
        lk_issue(12'h000, 3'd3, "R9 no src-check no drop");
        lk_issue(12'hFFF, 3'd7, "R9 member vid 4095");
        lk_issue(12'hFFF, 3'd0, "R9 drop vid 4095");
        lk_issue(12'h200, 3'd2, "R8 plain entry");
        @(negedge clk);

        // R6: reserved and idle codes capture data without touching the table
        poll_idle("R6");
        host_write(1'b0, 32'h200);
        host_write(1'b1, acc_word(8'h3C, 1'b1, 1'b0, 2'd3));
        host_rd(1'b1, v); chk("R6 reserved code reads idle", v, acc_word(8'h3C, 1'b1, 1'b0, 2'd0));
        host_write(1'b1, acc_word(8'h42, 1'b0, 1'b1, 2'd0));
        host_rd(1'b1, v); chk("R6 idle code captures data", v, acc_word(8'h42, 1'b0, 1'b1, 2'd0));
        lk_issue(12'h200, 3'd0, "R6 entry unchanged");
        @(negedge clk);

        // R7: writes while a read is in progress
        poll_idle("R7");
        host_write(1'b0, 32'h123);
        host_write(1'b1, acc_word(8'h00, 1'b0, 1'b0, 2'd1));
        host_write(1'b1, acc_word(8'hFF, 1'b1, 1'b1, 2'd2));
        host_write(1'b0, 32'h777);
        host_rd(1'b1, v); chk("R7 read result kept", v, acc_word(8'hA5, 1'b1, 1'b0, 2'd0));
        host_rd(1'b0, v); chk("R7 index write ignored", v, 32'h123);
        lk_issue(12'h123, 3'd1, "R7 entry not rewritten");
        @(negedge clk);

        // R10: neighbouring and boundary entries stay independent
        tbl_write(12'hFFF, 8'h0F, 1'b0, 1'b0, 32'h0);
        lk_issue(12'h000, 3'd0, "R10 vid 0 intact");
        lk_issue(12'hFFF, 3'd4, "R10 vid 4095 updated");
        lk_issue(12'h123, 3'd6, "R10 vid 0x123 intact");
        repeat (3) @(negedge clk);
        chk("R8 scoreboard drained", sb_q.size(), 32'd0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule